// File: doc/BRIEF.md
# Card Clock Divider and Gating

This block derives the clock sent to a memory card from a fast reference clock. An 8-bit setting selects the ratio. A setting of zero sends the reference straight through. Any other setting N produces a square wave with a period of 2·N reference cycles, so the ratio runs from 2 up to 510. Together with the card clock, the block gives a one-reference-cycle enable pulse that marks each rising card edge. Neighbouring logic that runs on the reference clock uses this pulse as its clock enable.

Four conditions stop the card clock:
- the enable input is low;
- low-power mode is on and the card path has been idle for eight card clock periods;
- a read transfer is still in progress and the FIFO is full;
- a write transfer is still in progress and the FIFO is empty.

Every stop, and every restart, takes effect only while the card clock is low, so a high phase is never cut short. The ratio setting is captured only while the clock is off. After each re-enable the divider starts from zero.

Top module: `cardclk_gen`

## Requirements
- R1: During and right after reset, `card_clk` and `clk_tick` are low.
- R2: With a captured setting N from 1 to 255, `card_clk` is high for N reference cycles and low for N reference cycles. After enable goes high at an edge E0, the first rising card edge comes at edge E0+N-1.
- R3: With a captured setting of 0, `card_clk` follows the reference clock while running, and `clk_tick` stays high.
- R4: When `clk_en` is low, `card_clk` settles low and `clk_tick` stays low.
- R5: The block captures `div_sel` only while the clock is off. A change made while `clk_en` is high has no effect on the period until the next disable.
- R6: With `lp_en` = 1 and no busy indication, the clock stops after exactly eight rising card edges. With `lp_en` = 0 it keeps running.
- R7: A stopped low-power clock resumes when `cmd_busy` goes high.
- R8: When `xfer_open` = 1 and `xfer_read` = 1, the clock is held low while `fifo_full` = 1.
- R9: When `xfer_open` = 1 and `xfer_read` = 0, the clock is held low while `fifo_empty` = 1.
- R10: The FIFO flags have no effect when `xfer_open` = 0, or when they do not match the transfer direction.
- R11: Each re-enable restarts the divider, so the first high and the first low phase are both full length.
- R12: A stop condition raised while `card_clk` is high lets that high phase finish at its full length of N cycles.
- R13: `cmd_busy` or `xfer_open` clears the idle count, so a busy pulse more often than every eight card periods keeps the clock running in low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 8 | Ratio setting: 0 = bypass, N = divide by 2·N |
| clk_en | input | 1 | Card clock enable |
| lp_en | input | 1 | Low-power idle stop enable |
| cmd_busy | input | 1 | Command path is not idle |
| fifo_full | input | 1 | Data FIFO full |
| fifo_empty | input | 1 | Data FIFO empty |
| xfer_read | input | 1 | Transfer direction: 1 = card to host, 0 = host to card |
| xfer_open | input | 1 | A data transfer is still incomplete |
| card_clk | output | 1 | Clock to the card |
| clk_tick | output | 1 | One reference-cycle pulse at each rising card edge |

## Verification
In divide mode, `card_clk` and `clk_tick` both change on the same reference edge that registers them. An input driven before edge E therefore shows at the first sample after E: the first rising edge of a restart is seen N-1 samples after the enable edge. In bypass, the gate is re-timed on the falling reference edge, so a stop condition shows from the next sample after the falling edge. The bench drives inputs and samples outputs 1 ns after each rising edge. It measures the length of each phase by counting consecutive samples of equal value. Stop conditions are checked by counting the rising edges or ticks seen over a fixed window.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;

  // Snapshot of the card path as seen by the gating logic.
  typedef struct packed {
    logic cmd_busy;
    logic fifo_full;
    logic fifo_empty;
    logic xfer_read;
    logic xfer_open;
  } path_status_t;

  // A transfer is pending and the buffer cannot serve its direction.
  function automatic logic buffer_blocked(path_status_t st);
    return st.xfer_open & (st.xfer_read ? st.fifo_full : st.fifo_empty);
  endfunction

  function automatic logic path_busy(path_status_t st);
    return st.cmd_busy | st.xfer_open;
  endfunction

endpackage

// File: rtl/cardclk_gatectl.sv
`timescale 1ns/1ps
module cardclk_gatectl
  import cardclk_pkg::*;
#(
  parameter int IDLE_CYC = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_en,
  input  logic         lp_en,
  input  logic         tick,
  input  path_status_t st,
  output logic         run_ok
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYC);

  logic [CW-1:0] idle_q;
  logic          busy;
  logic          idle_done;
  logic          lp_stop;

  assign busy      = path_busy(st);
  assign idle_done = (idle_q == IDLE_LIM);
  assign lp_stop   = lp_en & idle_done & ~busy;
  assign run_ok    = clk_en & ~buffer_blocked(st) & ~lp_stop;

  // Idle counter in card clock periods; saturates at the limit.
  always_ff @(posedge clk) begin
    if (rst || !clk_en || busy) begin
      idle_q <= '0;
    end else if (tick && !idle_done) begin
      idle_q <= idle_q + CW'(1);
    end
  end

  a_r13_idle_clear: assert property (@(posedge clk) disable iff (rst)
    (st.cmd_busy || st.xfer_open) |=> (idle_q == '0));

  a_r6_idle_bound: assert property (@(posedge clk) disable iff (rst)
    idle_q <= IDLE_LIM);

endmodule

// File: rtl/cardclk_divider.sv
`timescale 1ns/1ps
module cardclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             run_ok,
  input  logic             byp_gate,
  input  logic [DIV_W-1:0] div_sel,
  output logic             div_clk,
  output logic             tick,
  output logic             bypass
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             tick_q;
  logic             at_term;
  logic             may_load;

  assign bypass   = (ratio_q == '0);
  assign at_term  = (cnt_q == ratio_q - ONE);
  // New ratio only while disabled and both clock paths rest low.
  assign may_load = ~clk_en & ~clk_q & ~byp_gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (may_load) begin
        ratio_q <= div_sel;
        cnt_q   <= '0;
      end else if (bypass) begin
        cnt_q  <= '0;
        clk_q  <= 1'b0;
        tick_q <= byp_gate;
      end else if (at_term) begin
        if (clk_q) begin
          clk_q <= 1'b0;
          cnt_q <= '0;
        end else if (run_ok) begin
          clk_q  <= 1'b1;
          tick_q <= 1'b1;
          cnt_q  <= '0;
        end
        // otherwise hold low at the terminal count until allowed
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign div_clk = clk_q;
  assign tick    = tick_q;

  a_r5_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> $stable(ratio_q));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> (cnt_q < ratio_q));

  a_r12_full_high: assert property (@(posedge clk) disable iff (rst)
    (clk_q && !at_term) |=> clk_q);

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
    may_load |=> !tick_q);

endmodule

// File: rtl/cardclk_bypass_gate.sv
`timescale 1ns/1ps
module cardclk_bypass_gate (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic run_ok,
  input  logic div_clk,
  output logic card_clk,
  output logic gate
);
  logic gate_q;

  // Re-timed on the falling edge so the gate only moves while clk is low.
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_ok & bypass;
  end

  assign gate     = gate_q;
  assign card_clk = bypass ? (clk & gate_q) : div_clk;

  a_r3_gate_only_bypass: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> !gate_q);

endmodule

// File: rtl/cardclk_gen.sv
`timescale 1ns/1ps
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             clk_en,
  input  logic             lp_en,
  input  logic             cmd_busy,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             xfer_read,
  input  logic             xfer_open,
  output logic             card_clk,
  output logic             clk_tick
);
  path_status_t st;
  logic run_ok;
  logic byp_gate;
  logic div_clk;
  logic bypass;

  assign st = '{cmd_busy: cmd_busy, fifo_full: fifo_full, fifo_empty: fifo_empty,
                xfer_read: xfer_read, xfer_open: xfer_open};

  cardclk_gatectl #(.IDLE_CYC(IDLE_CYC)) u_gate (
    .clk(clk_ref), .rst(rst), .clk_en(clk_en), .lp_en(lp_en),
    .tick(clk_tick), .st(st), .run_ok(run_ok)
  );

  cardclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk_ref), .rst(rst), .clk_en(clk_en), .run_ok(run_ok),
    .byp_gate(byp_gate), .div_sel(div_sel), .div_clk(div_clk),
    .tick(clk_tick), .bypass(bypass)
  );

  cardclk_bypass_gate u_byp (
    .clk(clk_ref), .rst(rst), .bypass(bypass), .run_ok(run_ok),
    .div_clk(div_clk), .card_clk(card_clk), .gate(byp_gate)
  );

  a_r8_read_stall: assert property (@(posedge clk_ref) disable iff (rst)
    (!bypass && !div_clk && xfer_open && xfer_read && fifo_full) |=> !clk_tick);

  a_r9_write_stall: assert property (@(posedge clk_ref) disable iff (rst)
    (!bypass && !div_clk && xfer_open && !xfer_read && fifo_empty) |=> !clk_tick);

endmodule

// File: tb/sim_cardclk_gen.sv
`timescale 1ns/1ps
module sim_cardclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_sel = 8'd0;
  logic       clk_en = 1'b0, lp_en = 1'b0, cmd_busy = 1'b0;
  logic       fifo_full = 1'b0, fifo_empty = 1'b0, xfer_read = 1'b1, xfer_open = 1'b0;
  logic       card_clk, clk_tick;

  cardclk_gen u0 (
    .clk_ref(clk), .rst(rst), .div_sel(div_sel), .clk_en(clk_en), .lp_en(lp_en),
    .cmd_busy(cmd_busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .xfer_read(xfer_read), .xfer_open(xfer_open), .card_clk(card_clk), .clk_tick(clk_tick)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int checks = 0;
  int fails  = 0;

  // div, leading low samples, high samples, low samples
  localparam int VEC [0:4][0:3] = '{
    '{1, 0, 1, 1}, '{2, 1, 2, 2}, '{3, 2, 3, 3}, '{7, 6, 7, 7}, '{255, 254, 255, 255}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Disable, let the clock settle low, load a new ratio, enable again.
  task automatic restart(int d);
    clk_en  = 1'b0;
    div_sel = 8'(d);
    for (int i = 0; i < 600 && card_clk; i++) step();
    repeat (3) step();
    clk_en = 1'b1;
  endtask

  task automatic measure(output int lead, output int hi, output int lo, output int tk);
    lead = 0; hi = 0; lo = 0; tk = 0;
    step();
    for (int i = 0; i < 600 && !card_clk; i++) begin lead++; step(); end
    tk = clk_tick;
    for (int i = 0; i < 600 && card_clk; i++) begin hi++; step(); end
    for (int i = 0; i < 600 && !card_clk; i++) begin lo++; step(); end
  endtask

  // Sync to the next rising edge, return the full period length.
  task automatic period(output int p);
    p = 0;
    for (int i = 0; i < 600 && card_clk; i++) step();
    for (int i = 0; i < 600 && !card_clk; i++) step();
    for (int i = 0; i < 600 && card_clk; i++) begin p++; step(); end
    for (int i = 0; i < 600 && !card_clk; i++) begin p++; step(); end
  endtask

  task automatic count_ticks(int n, output int t);
    t = 0;
    repeat (n) begin step(); t += clk_tick; end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lead, hi, lo, tk, p, t;

    // R1 reset
    repeat (3) step();
    chk("R1 card_clk in reset", card_clk, 0);
    chk("R1 tick in reset", clk_tick, 0);
    rst = 1'b0;
    step();
    chk("R1 card_clk after reset", card_clk, 0);
    chk("R1 tick after reset", clk_tick, 0);

    // R2 / R11 vector table
    for (int v = 0; v < 5; v++) begin
      restart(VEC[v][0]);
      measure(lead, hi, lo, tk);
      chk($sformatf("R11 lead div=%0d", VEC[v][0]), lead, VEC[v][1]);
      chk($sformatf("R2 high div=%0d", VEC[v][0]), hi, VEC[v][2]);
      chk($sformatf("R2 low div=%0d", VEC[v][0]), lo, VEC[v][3]);
      chk($sformatf("R2 tick at rise div=%0d", VEC[v][0]), tk, 1);
    end

    // R5 ratio change while enabled is ignored
    restart(2);
    period(p);
    div_sel = 8'd5;
    period(p);
    chk("R5 period after live change", p, 4);
    period(p);
    chk("R5 period still old", p, 4);
    restart(5);
    measure(lead, hi, lo, tk);
    chk("R5 new ratio after disable high", hi, 5);

    // R4 disable
    clk_en = 1'b0;
    for (int i = 0; i < 20 && card_clk; i++) step();
    hi = 0; t = 0;
    repeat (30) begin step(); hi += card_clk; t += clk_tick; end
    chk("R4 card_clk held low", hi, 0);
    chk("R4 no ticks while off", t, 0);

    // R3 bypass
    restart(0);
    hi = 0; t = 0;
    repeat (20) begin step(); hi += card_clk; t += clk_tick; end
    chk("R3 bypass high phases", hi, 20);
    chk("R3 bypass ticks", t, 20);
    @(negedge clk); #1;
    chk("R3 bypass follows low phase", card_clk, 0);
    step();
    xfer_open = 1'b1; xfer_read = 1'b1; fifo_full = 1'b1;
    hi = 0;
    repeat (10) begin step(); hi += card_clk; end
    chk("R8 bypass read stall", hi, 0);
    xfer_open = 1'b0; fifo_full = 1'b0;

    // R12 / R8 read stall raised in high phase
    restart(4);
    for (int i = 0; i < 50 && !card_clk; i++) step();
    xfer_open = 1'b1; xfer_read = 1'b1; fifo_full = 1'b1;
    hi = 0;
    for (int i = 0; i < 50 && card_clk; i++) begin hi++; step(); end
    chk("R12 high phase completes", hi, 4);
    hi = 0;
    repeat (20) begin step(); hi += card_clk; end
    chk("R8 held low while full", hi, 0);
    fifo_full = 1'b0;
    count_ticks(10, t);
    chk("R8 resumes after full clears", (t > 0) ? 1 : 0, 1);

    // R9 write stall
    xfer_read = 1'b0; fifo_empty = 1'b1;
    for (int i = 0; i < 50 && card_clk; i++) step();
    hi = 0;
    repeat (20) begin step(); hi += card_clk; end
    chk("R9 held low while empty", hi, 0);
    fifo_empty = 1'b0;
    count_ticks(10, t);
    chk("R9 resumes after empty clears", (t > 0) ? 1 : 0, 1);

    // R10 flags ignored
    restart(3);
    xfer_open = 1'b1; xfer_read = 1'b1; fifo_empty = 1'b1;
    period(p);
    chk("R10 empty ignored on read", p, 6);
    xfer_open = 1'b0; fifo_empty = 1'b0; fifo_full = 1'b1;
    period(p);
    chk("R10 full ignored with no transfer", p, 6);
    fifo_full = 1'b0;

    // R6 / R7 / R13 low power
    lp_en = 1'b1;
    restart(1);
    count_ticks(60, t);
    chk("R6 stops after eight edges", t, 8);
    cmd_busy = 1'b1;
    count_ticks(10, t);
    chk("R7 resumes on command busy", (t >= 4) ? 1 : 0, 1);
    t = 0;
    for (int k = 0; k < 10; k++) begin
      cmd_busy = 1'b1;
      step(); t += clk_tick;
      cmd_busy = 1'b0;
      repeat (9) begin step(); t += clk_tick; end
    end
    chk("R13 busy pulses keep clock running", t, 50);
    lp_en = 1'b0;
    count_ticks(60, t);
    chk("R6 no stop without low power", t, 30);

    summary();
  end
endmodule